// File: doc/BRIEF.md
# Cache Block Maintenance Controller

This controller carries out single-block maintenance operations on a 4-way set-associative cache. It reads the tag, valid and dirty bits of one set through an external array port and clears valid bits through a masked clear strobe. It moves a whole dirty line to memory over a request/acknowledge write-back port. It drives an address-only broadcast request for the block-zero operation. Before a flush touches anything, the controller asks an external translation unit for a read-type protection check on the byte address.

A command is a 2-bit operation code with a 32-bit effective address. The address splits into three fields. Bits [4:0] are the byte offset within a 32-byte line, bits [11:5] select one of 128 sets, and bits [31:12] form the tag. The controller takes one command at a time. It reports the end of each command with a one-cycle done pulse, and that pulse carries a fault flag.

Top module: `cache_maint_ctrl`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid_i` is high and `busy_o` is low. `busy_o` is high from the cycle after acceptance through the done cycle. A command presented while `busy_o` is high is ignored and produces no bus, write-back or array activity.
- R2: A flush (op 2'b00) that hits a valid clean way clears that way's valid bit through `arr_clr_o`/`arr_clr_mask_o`. It raises no write-back and no broadcast.
- R3: A flush that hits a valid dirty way first writes the full 256-bit line of that way to memory. The write-back address is line-aligned (offset bits zero). The way is cleared only after `wb_ack_i`, and the request and address stay stable until acknowledged.
- R4: A flush whose tag matches no valid way completes with no clear, no write-back and no broadcast.
- R5: A flush first holds `prot_req_o` high with the full byte address on `prot_addr_o` until `prot_ack_i`. If `prot_fault_i` is high with the acknowledge, the command ends with `fault_o` high in its done cycle, and there is no write-back and no clear. `fault_o` is high only in a done cycle.
- R6: An instruction-block invalidate (op 2'b01) clears all four ways of the set selected by address bits [11:5]. It needs no tag match, raises no protection request, and leaves other sets unchanged. Its clear occurs in the cycle after acceptance and done follows one cycle later.
- R7: A block-zero (op 2'b10) is the only command that raises `bus_req_o`. It holds a line-aligned `bus_addr_o` until `bus_ack_i`, then completes. It leaves the array unchanged. At most one of the protection, write-back, broadcast and clear requests is active in any cycle.
- R8: An I/O ordering barrier (op 2'b11) completes with done in the cycle after acceptance and has no other effect.
- R9: `done_o` is a single-cycle pulse, and there is exactly one pulse per accepted command.
- R10: The tag (bits [31:12]) is compared against all four ways of the set at once. Only valid ways can hit, a match in any way selects that way, and offset bits do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 00 flush, 01 instruction invalidate, 10 block zero, 11 barrier |
| cmd_addr_i | input | 32 | Effective byte address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command complete, one cycle |
| fault_o | output | 1 | Protection fault, valid with done |
| prot_req_o | output | 1 | Read-type protection check request |
| prot_addr_o | output | 32 | Byte address under check |
| prot_ack_i | input | 1 | Check complete |
| prot_fault_i | input | 1 | Check failed, valid with acknowledge |
| arr_set_o | output | 7 | Set index to the tag/state array |
| arr_tag_i | input | 80 | Tags of the four ways, way 0 in the low bits |
| arr_valid_i | input | 4 | Valid bits of the four ways |
| arr_dirty_i | input | 4 | Dirty bits of the four ways |
| arr_clr_o | output | 1 | Clear strobe for masked ways of the set |
| arr_clr_mask_o | output | 4 | Ways to clear |
| line_way_o | output | 2 | Way whose line data is read |
| line_data_i | input | 256 | Line data of the selected way |
| wb_req_o | output | 1 | Write-back request |
| wb_addr_o | output | 32 | Line-aligned write-back address |
| wb_data_o | output | 256 | Line being written back |
| wb_ack_i | input | 1 | Write-back accepted |
| bus_req_o | output | 1 | Address-only broadcast request |
| bus_addr_o | output | 32 | Line-aligned broadcast address |
| bus_ack_i | input | 1 | Broadcast accepted |

## Verification
A barrier's done pulse is due one cycle after acceptance. An instruction invalidate's clear is due one cycle after acceptance and its done one cycle after that. The bench measures these as exact busy-cycle counts. Flush and block-zero results follow the protection, write-back and broadcast handshakes, whose acknowledges the bench delays by varying amounts. For these commands the scoreboard does not fix a cycle. It records every handshake and clear between acceptance and done, and compares the whole record with the expected item when done rises. Outputs are sampled on falling edges, and a clear seen before the write-back acknowledge counts as an ordering failure.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [1:0] {
    OP_FLUSH = 2'b00,
    OP_IINV  = 2'b01,
    OP_ZERO  = 2'b10,
    OP_SYNC  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK,
    S_LOOK,
    S_WB,
    S_CLR,
    S_INV,
    S_BCAST,
    S_DONE
  } st_e;

endpackage

// File: rtl/cmc_tag_match.sv
module cmc_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0]      tag_i,
  input  logic [WAYS*TAG_W-1:0] way_tag_i,
  input  logic [WAYS-1:0]       way_valid_i,
  input  logic [WAYS-1:0]       way_dirty_i,
  output logic                  hit_o,
  output logic                  hit_dirty_o,
  output logic [WAYS-1:0]       hit_mask_o,
  output logic [WAY_W-1:0]      hit_way_o
);

  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_valid_i[g] && (way_tag_i[g*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o       = |match;
  assign hit_dirty_o = |(match & way_dirty_i);
  assign hit_mask_o  = match;

endmodule

// File: rtl/cmc_fsm.sv
module cmc_fsm
  import cmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  op_e  cmd_op_i,
  input  logic prot_ack_i,
  input  logic prot_fault_i,
  input  logic hit_i,
  input  logic hit_dirty_i,
  input  logic wb_ack_i,
  input  logic bus_ack_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o,
  output logic fault_o,
  output logic prot_req_o,
  output logic wb_req_o,
  output logic bus_req_o,
  output logic clr_o,
  output logic clr_all_o
);

  st_e  state_q, state_d;
  logic fault_q;

  assign accept_o = (state_q == S_IDLE) && cmd_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) begin
        unique case (cmd_op_i)
          OP_FLUSH: state_d = S_CHK;
          OP_IINV:  state_d = S_INV;
          OP_ZERO:  state_d = S_BCAST;
          default:  state_d = S_DONE;
        endcase
      end
      S_CHK:   if (prot_ack_i) state_d = prot_fault_i ? S_DONE : S_LOOK;
      S_LOOK:  state_d = (hit_i && hit_dirty_i) ? S_WB : S_DONE;
      S_WB:    if (wb_ack_i) state_d = S_CLR;
      S_CLR:   state_d = S_DONE;
      S_INV:   state_d = S_DONE;
      S_BCAST: if (bus_ack_i) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) fault_q <= 1'b0;
      else if (state_q == S_CHK && prot_ack_i) fault_q <= prot_fault_i;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign fault_o    = done_o && fault_q;
  assign prot_req_o = (state_q == S_CHK);
  assign wb_req_o   = (state_q == S_WB);
  assign bus_req_o  = (state_q == S_BCAST);
  assign clr_all_o  = (state_q == S_INV);
  // clean hit clears at lookup; dirty hit clears only after write-back
  assign clr_o      = clr_all_o || (state_q == S_CLR) ||
                      ((state_q == S_LOOK) && hit_i && !hit_dirty_i);

endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [1:0]            cmd_op_i,
  input  logic [ADDR_W-1:0]     cmd_addr_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  fault_o,
  output logic                  prot_req_o,
  output logic [ADDR_W-1:0]     prot_addr_o,
  input  logic                  prot_ack_i,
  input  logic                  prot_fault_i,
  output logic [IDX_W-1:0]      arr_set_o,
  input  logic [WAYS*TAG_W-1:0] arr_tag_i,
  input  logic [WAYS-1:0]       arr_valid_i,
  input  logic [WAYS-1:0]       arr_dirty_i,
  output logic                  arr_clr_o,
  output logic [WAYS-1:0]       arr_clr_mask_o,
  output logic [WAY_W-1:0]      line_way_o,
  input  logic [LINE_W-1:0]     line_data_i,
  output logic                  wb_req_o,
  output logic [ADDR_W-1:0]     wb_addr_o,
  output logic [LINE_W-1:0]     wb_data_o,
  input  logic                  wb_ack_i,
  output logic                  bus_req_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  input  logic                  bus_ack_i
);

  logic [ADDR_W-1:0] addr_q;
  logic              accept, hit, hit_dirty, clr_all;
  logic [WAYS-1:0]   hit_mask;
  logic [ADDR_W-1:0] line_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= cmd_addr_i;
  end

  cmc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
    .tag_i       (addr_q[ADDR_W-1 -: TAG_W]),
    .way_tag_i   (arr_tag_i),
    .way_valid_i (arr_valid_i),
    .way_dirty_i (arr_dirty_i),
    .hit_o       (hit),
    .hit_dirty_o (hit_dirty),
    .hit_mask_o  (hit_mask),
    .hit_way_o   (line_way_o)
  );

  cmc_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmc_pkg::op_e'(cmd_op_i)),
    .prot_ack_i   (prot_ack_i),
    .prot_fault_i (prot_fault_i),
    .hit_i        (hit),
    .hit_dirty_i  (hit_dirty),
    .wb_ack_i     (wb_ack_i),
    .bus_ack_i    (bus_ack_i),
    .accept_o     (accept),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .prot_req_o   (prot_req_o),
    .wb_req_o     (wb_req_o),
    .bus_req_o    (bus_req_o),
    .clr_o        (arr_clr_o),
    .clr_all_o    (clr_all)
  );

  assign line_addr      = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign arr_set_o      = addr_q[OFF_W +: IDX_W];
  assign arr_clr_mask_o = clr_all ? {WAYS{1'b1}} : hit_mask;
  assign prot_addr_o    = addr_q;
  assign wb_addr_o      = line_addr;
  assign wb_data_o      = line_data_i;
  assign bus_addr_o     = line_addr;

endmodule

// File: rtl/cmc_checks.sv
module cmc_checks #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              prot_req_o,
  input logic              prot_ack_i,
  input logic [ADDR_W-1:0] prot_addr_o,
  input logic              wb_req_o,
  input logic              wb_ack_i,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic              bus_req_o,
  input logic              bus_ack_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              arr_clr_o,
  input logic [WAYS-1:0]   arr_clr_mask_o
);

  AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_req_o || wb_req_o || bus_req_o || arr_clr_o) |-> busy_o); // R1

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_FAULT_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o); // R5

  AST_PROT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_req_o && !prot_ack_i) |=> (prot_req_o && $stable(prot_addr_o))); // R5

  AST_WB_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_addr_o))); // R3

  AST_CLR_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wb_req_o) |-> arr_clr_o); // R3

  AST_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o))); // R7

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prot_req_o, wb_req_o, bus_req_o, arr_clr_o})); // R7

  AST_CLR_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_clr_o |-> (arr_clr_mask_o != '0)); // R6

endmodule

bind cache_maint_ctrl cmc_checks #(.ADDR_W(ADDR_W), .WAYS(WAYS)) i_cmc_checks (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .fault_o        (fault_o),
  .prot_req_o     (prot_req_o),
  .prot_ack_i     (prot_ack_i),
  .prot_addr_o    (prot_addr_o),
  .wb_req_o       (wb_req_o),
  .wb_ack_i       (wb_ack_i),
  .wb_addr_o      (wb_addr_o),
  .bus_req_o      (bus_req_o),
  .bus_ack_i      (bus_ack_i),
  .bus_addr_o     (bus_addr_o),
  .arr_clr_o      (arr_clr_o),
  .arr_clr_mask_o (arr_clr_mask_o)
);

// File: tb/test_cache_maint_ctrl.sv
module test_cache_maint_ctrl;
  localparam int AW = 32, SETS = 128, WAYS = 4, IDX_W = 7, TAG_W = 20, LW = 256, WW = 2;
  localparam logic [1:0] OP_FL = 2'b00, OP_IV = 2'b01, OP_ZR = 2'b10, OP_SY = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                  cmd_valid_i = 1'b0;
  logic [1:0]            cmd_op_i = '0;
  logic [AW-1:0]         cmd_addr_i = '0;
  logic                  busy_o, done_o, fault_o, prot_req_o;
  logic [AW-1:0]         prot_addr_o;
  logic                  prot_ack_i = 1'b0;
  logic                  prot_fault_i;
  logic [IDX_W-1:0]      arr_set_o;
  logic [WAYS*TAG_W-1:0] arr_tag_i;
  logic [WAYS-1:0]       arr_valid_i, arr_dirty_i;
  logic                  arr_clr_o;
  logic [WAYS-1:0]       arr_clr_mask_o;
  logic [WW-1:0]         line_way_o;
  logic [LW-1:0]         line_data_i;
  logic                  wb_req_o;
  logic [AW-1:0]         wb_addr_o;
  logic [LW-1:0]         wb_data_o;
  logic                  wb_ack_i = 1'b0;
  logic                  bus_req_o;
  logic [AW-1:0]         bus_addr_o;
  logic                  bus_ack_i = 1'b0;

  cache_maint_ctrl i_cache_maint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i, .cmd_op_i, .cmd_addr_i,
    .busy_o, .done_o, .fault_o, .prot_req_o, .prot_addr_o, .prot_ack_i, .prot_fault_i,
    .arr_set_o, .arr_tag_i, .arr_valid_i, .arr_dirty_i, .arr_clr_o, .arr_clr_mask_o,
    .line_way_o, .line_data_i, .wb_req_o, .wb_addr_o, .wb_data_o, .wb_ack_i,
    .bus_req_o, .bus_addr_o, .bus_ack_i
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // cache array model (environment)
  logic [WAYS-1:0]  m_vld [SETS];
  logic [WAYS-1:0]  m_drt [SETS];
  logic [TAG_W-1:0] m_tag [SETS][WAYS];

  function automatic logic [LW-1:0] line_val(input logic [IDX_W-1:0] s, input logic [WW-1:0] w);
    logic [31:0] seed;
    logic [LW-1:0] v;
    seed = 32'h5A00_0000 ^ (32'(s) << 8) ^ 32'(w);
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = seed + 32'(k) * 32'h0101_0101;
    return v;
  endfunction

  always_comb begin
    for (int w = 0; w < WAYS; w++) arr_tag_i[w*TAG_W +: TAG_W] = m_tag[arr_set_o][w];
    arr_valid_i = m_vld[arr_set_o];
    arr_dirty_i = m_drt[arr_set_o];
  end
  assign line_data_i = line_val(arr_set_o, line_way_o);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        m_vld[s] <= '0;
        m_drt[s] <= '0;
        for (int w = 0; w < WAYS; w++) m_tag[s][w] <= TAG_W'(s * 4 + w);
      end
      m_vld[3] <= 4'b0101; m_drt[3] <= 4'b0100;
      m_tag[3][0] <= 20'h1A2B3; m_tag[3][1] <= 20'h77777; m_tag[3][2] <= 20'h0BEEF;
      m_vld[10] <= 4'b1000; m_drt[10] <= 4'b1000; m_tag[10][3] <= 20'hFACE1;
      m_vld[20] <= 4'b1111; m_drt[20] <= 4'b0010;
      for (int w = 0; w < WAYS; w++) m_tag[20][w] <= 20'h00100 + TAG_W'(w);
      m_vld[21] <= 4'b0001; m_tag[21][0] <= 20'h00100;
    end else if (arr_clr_o) begin
      m_vld[arr_set_o] <= m_vld[arr_set_o] & ~arr_clr_mask_o;
      m_drt[arr_set_o] <= m_drt[arr_set_o] & ~arr_clr_mask_o;
    end
  end

  // scoreboard items
  typedef struct {
    bit            fault;
    int            prot;
    logic [AW-1:0] prot_addr;
    int            wb;
    logic [AW-1:0] wb_addr;
    logic [LW-1:0] wb_data;
    int            bus;
    logic [AW-1:0] bus_addr;
    logic [3:0]    clr;
    int            lat;
  } exp_t;
  exp_t  exp_q[$];
  string req_q[$];

  int prot_dly = 0, wb_dly = 0, bus_dly = 0;
  bit fault_cfg = 1'b0;
  int pc = 0, wc = 0, bc = 0;
  assign prot_fault_i = prot_ack_i & fault_cfg;

  int ev_prot = 0, ev_wb = 0, ev_bus = 0, lat = 0;
  logic [AW-1:0] ev_prot_addr = '0, ev_wb_addr = '0, ev_bus_addr = '0;
  logic [LW-1:0] ev_wb_data = '0;
  logic [3:0] ev_clr = '0;
  bit order_bad = 1'b0;

  // monitor and responders, all on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prot_ack_i) ev_prot++;
      if (wb_ack_i)   ev_wb++;
      if (bus_ack_i)  ev_bus++;
      if (arr_clr_o) begin
        ev_clr = ev_clr | arr_clr_mask_o;
        if (exp_q.size() > 0 && exp_q[0].wb > 0 && ev_wb == 0) order_bad = 1'b1;
      end
      if (busy_o) lat++;
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t  e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(fault_o == e.fault, r, "fault", LW'(fault_o), LW'(e.fault));
          chk(ev_prot == e.prot, r, "prot handshakes", LW'(ev_prot), LW'(e.prot));
          if (e.prot > 0) chk(ev_prot_addr == e.prot_addr, r, "prot addr", LW'(ev_prot_addr), LW'(e.prot_addr));
          chk(ev_wb == e.wb, r, "write-backs", LW'(ev_wb), LW'(e.wb));
          if (e.wb > 0) begin
            chk(ev_wb_addr == e.wb_addr, r, "wb addr", LW'(ev_wb_addr), LW'(e.wb_addr));
            chk(ev_wb_data == e.wb_data, r, "wb data", ev_wb_data, e.wb_data);
          end
          chk(ev_bus == e.bus, r, "broadcasts", LW'(ev_bus), LW'(e.bus));
          if (e.bus > 0) chk(ev_bus_addr == e.bus_addr, r, "bus addr", LW'(ev_bus_addr), LW'(e.bus_addr));
          chk(ev_clr == e.clr, r, "clear mask", LW'(ev_clr), LW'(e.clr));
          chk(!order_bad, r, "clear before wb ack", LW'(order_bad), 0);
          if (e.lat >= 0) chk(lat == e.lat, r, "busy cycles", LW'(lat), LW'(e.lat));
        end
        ev_prot = 0; ev_wb = 0; ev_bus = 0; lat = 0; ev_clr = '0; order_bad = 1'b0;
      end
    end
    if (prot_ack_i) prot_ack_i = 1'b0;
    else if (prot_req_o) begin
      if (pc >= prot_dly) begin prot_ack_i = 1'b1; ev_prot_addr = prot_addr_o; pc = 0; end
      else pc++;
    end
    if (wb_ack_i) wb_ack_i = 1'b0;
    else if (wb_req_o) begin
      if (wc >= wb_dly) begin wb_ack_i = 1'b1; ev_wb_addr = wb_addr_o; ev_wb_data = wb_data_o; wc = 0; end
      else wc++;
    end
    if (bus_ack_i) bus_ack_i = 1'b0;
    else if (bus_req_o) begin
      if (bc >= bus_dly) begin bus_ack_i = 1'b1; ev_bus_addr = bus_addr_o; bc = 0; end
      else bc++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R9 watchdog actual %0d expected <50000", cyc);
      finish_run();
    end
  end

  function automatic logic [AW-1:0] mk(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] s,
                                       input logic [4:0] o);
    return {t, s, o};
  endfunction

  task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a, input bit flt,
                        input bit hold_busy, input string req);
    exp_t e;
    logic [IDX_W-1:0] s;
    s = a[11:5];
    e.fault = 0; e.prot = 0; e.prot_addr = a; e.wb = 0; e.wb_addr = {a[31:5], 5'b0};
    e.wb_data = '0; e.bus = 0; e.bus_addr = {a[31:5], 5'b0}; e.clr = '0; e.lat = -1;
    case (op)
      OP_FL: begin
        e.prot = 1;
        if (flt) e.fault = 1;
        else begin
          for (int w = 0; w < WAYS; w++) begin
            if (m_vld[s][w] && m_tag[s][w] == a[31:12]) begin
              e.clr[w] = 1'b1;
              if (m_drt[s][w]) begin e.wb = 1; e.wb_data = line_val(s, WW'(w)); end
            end
          end
        end
      end
      OP_IV: begin e.clr = 4'b1111; e.lat = 2; end
      OP_ZR: e.bus = 1;
      default: e.lat = 1;
    endcase
    fault_cfg = flt;
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a;
    @(negedge clk);
    if (hold_busy) begin
      cmd_op_i = OP_ZR; cmd_addr_i = 32'hDEAD_BEE0;
      chk(busy_o == 1'b1, "R1", "busy after accept", LW'(busy_o), 1);
      @(negedge clk);
    end
    cmd_valid_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fault_o, "R1", "reset idle", LW'({busy_o, done_o, fault_o}), 0);
    chk(!prot_req_o && !wb_req_o && !bus_req_o && !arr_clr_o, "R7", "reset requests",
        LW'({prot_req_o, wb_req_o, bus_req_o, arr_clr_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_cmd(OP_SY, 32'h1234_5678, 0, 0, "R8");
    do_cmd(OP_FL, mk(20'h55555, 7'd3, 5'd0), 0, 0, "R4");
    do_cmd(OP_FL, mk(20'h77777, 7'd3, 5'd9), 0, 0, "R10");  // tag of invalid way
    prot_dly = 2;
    do_cmd(OP_FL, mk(20'h1A2B3, 7'd3, 5'h14), 0, 0, "R2");
    wb_dly = 3;
    do_cmd(OP_FL, mk(20'h0BEEF, 7'd3, 5'h1F), 0, 0, "R3");
    do_cmd(OP_FL, mk(20'h0BEEF, 7'd3, 5'h00), 0, 0, "R4");  // now invalid
    do_cmd(OP_FL, mk(20'hFACE1, 7'd10, 5'h07), 1, 0, "R5");
    prot_dly = 0; wb_dly = 0;
    do_cmd(OP_FL, mk(20'hFACE1, 7'd10, 5'h03), 0, 0, "R10");  // way 3, survived fault
    do_cmd(OP_IV, mk(20'hABCDE, 7'd20, 5'h11), 0, 1, "R6");
    do_cmd(OP_FL, mk(20'h00101, 7'd20, 5'h00), 0, 0, "R6");  // gone after invalidate
    do_cmd(OP_FL, mk(20'h00100, 7'd21, 5'h00), 0, 0, "R6");  // neighbour set intact
    bus_dly = 2;
    do_cmd(OP_ZR, mk(20'h1A2B3, 7'd3, 5'h0C), 0, 0, "R7");
    do_cmd(OP_SY, 32'h0, 0, 0, "R8");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, "R9", "idle at end", LW'(exp_q.size()), 0);
    finish_run();
  end
endmodule